// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns a single external interrupt pin into an interrupt request. A two-bit sense selector picks one of three trigger conditions: low level, falling edge or rising edge. An enable input gates the request line.

An edge that matches the selected direction sets a sticky flag. The flag holds until a one-cycle clear pulse removes it. The low-level path is different: it is purely combinational from the raw pin and holds no state. Because of that, it keeps working while the I/O clock is gated, which lets a held-low pin act as a wake request during deep sleep.

Edge detection runs through a synchronizer and is qualified by an I/O clock-enable input. An edge whose detection cycle falls inside a gated interval is lost. Whatever drives the pin counts the same way, so firmware can raise an interrupt by writing the pin when the pad is an output.

Top module: `ext_int_sense`

## Requirements
- R1: After reset is released the edge flag is clear, so with enable high and a falling-edge selection the request is low until an edge arrives.
- R2: With sense code 2'b00 (low level) and enable high, irq_o follows the inverted raw pin combinationally, with no clock edge needed. It is high exactly while the pin is low and leaves no flag behind.
- R3: The low-level request of R2 also works while io_clk_en_i is low.
- R4: With sense code 2'b10 (falling edge), a high-to-low pin change sets the flag. irq_o rises after the third rising clock edge following the change and stays high after the pin returns high.
- R5: With sense code 2'b11 (rising edge), a low-to-high pin change sets the flag with the same three-edge latency as R4, and the flag is sticky.
- R6: A pin change in the direction opposite to the selected edge does not set the flag.
- R7: An edge whose detection cycle has io_clk_en_i low never sets the flag. A level change made entirely while the clock is gated is not reported when the clock resumes. The next real edge after resume is detected normally.
- R8: A one-cycle pulse on flag_clr_i clears the flag at the next rising edge, and irq_o is low after that edge.
- R9: When a detected edge and flag_clr_i coincide in the same cycle, the flag stays set.
- R10: Sense code 2'b01 is reserved: it produces no request at any pin level and sets no flag.
- R11: With enable_i low, irq_o stays low in every mode. A flag set meanwhile is kept and appears on irq_o as soon as enable_i goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | External interrupt pin (raw, asynchronous) |
| io_clk_en_i | input | 1 | High when the I/O clock is running; low models sleep gating |
| sense_i | input | 2 | Trigger selection: 00 low level, 01 reserved, 10 falling, 11 rising |
| enable_i | input | 1 | Request enable |
| flag_clr_i | input | 1 | One-cycle pulse that clears the edge flag |
| irq_o | output | 1 | Interrupt / wake request |

## Verification
The pin is driven through low and high levels with no clock activity. This separates the combinational level path from the clocked edge path, both with the clock enable high and with it low. Falling and rising transitions are each applied under both edge selections, which shows that direction is decoded and not merely "any change". A transition made wholly inside a gated window, followed by resume, distinguishes a detector that compares across the gap from one that does not. Placing the clear pulse on the exact detection cycle exposes the set-versus-clear priority.

// File: rtl/eis_pkg.sv
package eis_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam int unsigned SYNC_STAGES_DEFAULT = 2;

    function automatic logic edge_match(sense_e mode, edge_t ev);
        logic hit;
        case (mode)
            SENSE_FALL: hit = ev.fall;
            SENSE_RISE: hit = ev.rise;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic level_match(sense_e mode, logic pin);
        return (mode == SENSE_LOW) && !pin;
    endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) chain_q[0] <= async_i;
        end else begin : g_next
            always_ff @(posedge clk) chain_q[g] <= chain_q[g-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/eis_edge_detect.sv
module eis_edge_detect
    import eis_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cur_i,
    input  logic  clk_en_i,
    output edge_t edge_o
);
    logic prev_q;

    // Previous value always tracks, so a change made while gated is absorbed.
    always_ff @(posedge clk) prev_q <= cur_i;

    always_comb begin
        edge_o.rise = clk_en_i && cur_i && !prev_q;
        edge_o.fall = clk_en_i && !cur_i && prev_q;
    end

    // R7: nothing leaves the detector while the I/O clock is gated
    a_r7_gated_quiet: assert property (@(posedge clk) disable iff (rst)
        !clk_en_i |-> (edge_o == '0));

    a_r6_single_dir: assert property (@(posedge clk) disable iff (rst)
        !(edge_o.rise && edge_o.fall));
endmodule

// File: rtl/eis_flag.sv
module eis_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8: a lone clear empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    // R9: a set in the same cycle as a clear wins
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/ext_int_sense.sv
module ext_int_sense
    import eis_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic       io_clk_en_i,
    input  logic [1:0] sense_i,
    input  logic       enable_i,
    input  logic       flag_clr_i,
    output logic       irq_o
);
    sense_e mode;
    logic   pin_sync;
    edge_t  edges;
    logic   edge_hit;
    logic   level_hit;
    logic   flag_q;

    assign mode = sense_e'(sense_i);

    eis_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eis_edge_detect i_edge (
        .clk      (clk),
        .rst      (rst),
        .cur_i    (pin_sync),
        .clk_en_i (io_clk_en_i),
        .edge_o   (edges)
    );

    assign edge_hit = edge_match(mode, edges);

    eis_flag i_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (edge_hit),
        .clr_i  (flag_clr_i),
        .flag_o (flag_q)
    );

    // Level path bypasses every flop so it works without the I/O clock.
    assign level_hit = level_match(mode, pin_i);
    assign irq_o     = enable_i && (flag_q || level_hit);

    // R2: low level with enable always requests
    a_r2_level_req: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW && enable_i && !pin_i) |-> irq_o);

    // R10: reserved code never sets the flag
    a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_RSVD) |=> !$rose(flag_q));

    // R2: level mode leaves no flag behind
    a_r2_no_flag: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW) |=> !$rose(flag_q));

    // R7: gated clock never raises the flag
    a_r7_no_set_gated: assert property (@(posedge clk) disable iff (rst)
        !io_clk_en_i |=> !$rose(flag_q));

    // R11: disabled means silent
    a_r11_masked: assert property (@(posedge clk) disable iff (rst)
        !enable_i |-> !irq_o);
endmodule

// File: tb/test_ext_int_sense.sv
module test_ext_int_sense;
    logic       clk = 1'b0;
    logic       rst;
    logic       pin;
    logic       clk_en;
    logic [1:0] sense;
    logic       enable;
    logic       flag_clr;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ext_int_sense i_ext_int_sense (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .io_clk_en_i (clk_en),
        .sense_i     (sense),
        .enable_i    (enable),
        .flag_clr_i  (flag_clr),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic settle(input logic level);
        pin = level;
        cyc(4);
        clear_flag();
    endtask

    task automatic t_reset();
        check("R1 after reset", irq, 1'b0);
        cyc(3);
        check("R1 idle after reset", irq, 1'b0);
    endtask

    task automatic t_level();
        sense = 2'b00;
        settle(1'b1);
        #1 check("R2 pin high", irq, 1'b0);
        pin = 1'b0;
        #1 check("R2 pin low immediate", irq, 1'b1);
        cyc(3);
        check("R2 pin held low", irq, 1'b1);
        pin = 1'b1;
        #1 check("R2 release, no flag", irq, 1'b0);
        cyc(4);
        check("R2 no residue", irq, 1'b0);
    endtask

    task automatic t_level_gated();
        sense  = 2'b00;
        clk_en = 1'b0;
        pin    = 1'b0;
        #1 check("R3 gated low", irq, 1'b1);
        cyc(3);
        check("R3 gated held", irq, 1'b1);
        pin = 1'b1;
        #1 check("R3 gated release", irq, 1'b0);
        clk_en = 1'b1;
        cyc(4);
    endtask

    task automatic t_fall();
        sense = 2'b10;
        settle(1'b1);
        pin = 1'b0;
        cyc(2);
        check("R4 before latency", irq, 1'b0);
        cyc(1);
        check("R4 flag set", irq, 1'b1);
        pin = 1'b1;
        cyc(4);
        check("R4 sticky", irq, 1'b1);
        clear_flag();
        check("R8 cleared", irq, 1'b0);
    endtask

    task automatic t_rise();
        sense = 2'b11;
        settle(1'b0);
        pin = 1'b1;
        cyc(2);
        check("R5 before latency", irq, 1'b0);
        cyc(1);
        check("R5 flag set", irq, 1'b1);
        pin = 1'b0;
        cyc(4);
        check("R5 sticky", irq, 1'b1);
        clear_flag();
        check("R8 cleared after rise", irq, 1'b0);
    endtask

    task automatic t_wrong_dir();
        sense = 2'b11;
        settle(1'b1);
        pin = 1'b0;
        cyc(4);
        check("R6 fall ignored in rise mode", irq, 1'b0);
        sense = 2'b10;
        pin = 1'b1;
        cyc(4);
        check("R6 rise ignored in fall mode", irq, 1'b0);
    endtask

    task automatic t_gating();
        sense = 2'b10;
        settle(1'b1);
        clk_en = 1'b0;
        pin = 1'b0;
        cyc(5);
        check("R7 gated edge lost", irq, 1'b0);
        clk_en = 1'b1;
        cyc(5);
        check("R7 no stale edge on resume", irq, 1'b0);
        pin = 1'b1;
        cyc(4);
        pin = 1'b0;
        cyc(3);
        check("R7 rearmed after resume", irq, 1'b1);
        clear_flag();
    endtask

    task automatic t_set_wins();
        sense = 2'b11;
        settle(1'b0);
        pin = 1'b1;
        cyc(3);
        check("R9 setup flag", irq, 1'b1);
        pin = 1'b0;
        cyc(4);
        pin = 1'b1;
        cyc(2);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        check("R9 set beats clear", irq, 1'b1);
        clear_flag();
        check("R8 clear alone", irq, 1'b0);
    endtask

    task automatic t_reserved();
        sense = 2'b01;
        settle(1'b1);
        pin = 1'b0;
        #1 check("R10 low level ignored", irq, 1'b0);
        cyc(4);
        pin = 1'b1;
        cyc(4);
        check("R10 edges ignored", irq, 1'b0);
        pin = 1'b0;
        cyc(4);
        sense = 2'b10;
        cyc(2);
        check("R10 no flag left behind", irq, 1'b0);
        pin = 1'b1;
        cyc(4);
    endtask

    task automatic t_enable();
        sense = 2'b10;
        settle(1'b1);
        enable = 1'b0;
        pin = 1'b0;
        cyc(4);
        check("R11 masked edge", irq, 1'b0);
        enable = 1'b1;
        #1 check("R11 kept flag shows", irq, 1'b1);
        clear_flag();
        enable = 1'b0;
        sense = 2'b00;
        #1 check("R11 masked level", irq, 1'b0);
        enable = 1'b1;
        pin = 1'b1;
        cyc(4);
    endtask

    initial begin
        rst = 1'b1; pin = 1'b1; clk_en = 1'b1; sense = 2'b10;
        enable = 1'b0; flag_clr = 1'b0;
        cyc(5);
        rst = 1'b0;
        enable = 1'b1;
        #1;
        t_reset();
        t_level();
        t_level_gated();
        t_fall();
        t_rise();
        t_wrong_dir();
        t_gating();
        t_set_wins();
        t_reserved();
        t_enable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule